// File: doc/BRIEF.md
# Conjugate-Symmetric Tone Mapper for Multitone Transmit

This block sits between a constellation mapper and an inverse FFT in a multitone transmitter. It takes one complex value per subcarrier and builds the full frequency vector for one symbol. Each subcarrier value goes into its own bin. Its conjugate goes into the mirrored bin at the same time. An N-point inverse transform of the buffer then gives N purely real time samples. Two sizes are supported: a wide mode with 512 bins and 256 subcarriers, and a narrow mode with 64 bins and 32 subcarriers.

Subcarrier 0 has no mirror partner. It carries two real numbers: its real part becomes the DC bin and its imaginary part becomes the Nyquist bin N/2. Both of those bins get a zero imaginary part. The writer streams (tone, I, Q) triples in any order. When every subcarrier of the symbol has been written, `symbol_ready` rises. The transform engine then reads bins in natural order through a one-cycle-latency read port. It pulses `rd_done` to release the buffer for the next symbol.

The controller is a three-state machine:
- `ST_EMPTY`: no tone is written yet, and the mode input is followed.
- `ST_FILL`: the mode is latched and tones are being collected.
- `ST_READY`: the buffer is complete and write-protected.

Its transitions are:
- EMPTY→FILL on the first accepted write.
- EMPTY/FILL→READY on the write that completes the set of distinct tones.
- READY→EMPTY on `rd_done`.

Top module: `dmt_tone_mirror`

## Requirements
- R1: After reset, `symbol_ready` is 0 and every bin reads as zero.
- R2: A write of tone k (1 ≤ k < N/2) stores (I, Q) in bin k.
- R3: The same write stores (I, −Q) in bin N−k.
- R4: Negating Q saturates: Q = −32768 puts +32767 in the mirrored bin.
- R5: A write of tone 0 stores (I, 0) in bin 0 and (Q, 0) in bin N/2.
- R6: `symbol_ready` rises on the clock edge that captures the last missing distinct tone, and not before.
- R7: Rewriting a tone in the same symbol keeps the newest value, and the rewrite does not count as a new tone.
- R8: A tone index ≥ N/2 (possible in the 64-bin mode) is ignored: no bin changes and it does not count.
- R9: Writes while `symbol_ready` is 1 are ignored, and `symbol_ready` stays 1 until `rd_done`.
- R10: `rd_done` while ready clears `symbol_ready` on the next edge, and the next symbol counts tones from zero.
- R11: `mode_small` (1 = 64 bins, 0 = 512 bins) is sampled at the first write of a symbol. Later changes of the input have no effect until the symbol is released.
- R12: `rd_re`/`rd_im` show bin `rd_addr` one cycle after it is presented. Addresses ≥ N read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_small | input | 1 | 1 selects 64 bins, 0 selects 512 bins |
| wr_valid | input | 1 | Subcarrier write strobe |
| wr_tone | input | 8 | Subcarrier index |
| wr_re | input | 16 | In-phase value, signed |
| wr_im | input | 16 | Quadrature value, signed |
| rd_addr | input | 9 | Bin to read |
| rd_done | input | 1 | Release the completed symbol |
| rd_re | output | 16 | Real part of the addressed bin |
| rd_im | output | 16 | Imaginary part of the addressed bin |
| symbol_ready | output | 1 | All subcarriers of the symbol are present |

## Verification
The hardest situation to reach is a symbol whose completion depends on the distinct-tone bookkeeping rather than on the raw number of write strobes. The bench interleaves a duplicate write and an out-of-range write before the final tone of a narrow symbol, and flips the mode input in mid-fill. An early or missing `symbol_ready`, or a wrong bin size, is then visible at the ports. A following wide symbol plants the most negative quadrature value, which exercises the saturating conjugate. That symbol also only completes after all 256 fresh tones, which confirms the counter restarted after release.

// File: rtl/tm_pkg.sv
package tm_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_READY = 2'd2
    } tm_state_t;
endpackage

// File: rtl/tm_conj.sv
// Builds the lower-half and mirrored upper-half entries for one subcarrier.
module tm_conj #(
    parameter int DW = 16,
    parameter int TW = 8
) (
    input  logic [TW-1:0]        tone,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic signed [DW-1:0] lo_re,
    output logic signed [DW-1:0] lo_im,
    output logic signed [DW-1:0] hi_re,
    output logic signed [DW-1:0] hi_im
);
    localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};

    logic signed [DW-1:0] neg_im;

    always_comb begin
        neg_im = (in_im == MIN_V) ? MAX_V : -in_im;
        if (tone == '0) begin
            lo_re = in_re;
            lo_im = '0;
            hi_re = in_im;
            hi_im = '0;
        end else begin
            lo_re = in_re;
            lo_im = in_im;
            hi_re = in_re;
            hi_im = neg_im;
        end
    end
endmodule

// File: rtl/tm_bank.sv
// One half of the bin buffer: one write port, one combinational read port.
module tm_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [DW-1:0] wre,
    input  logic signed [DW-1:0] wim,
    input  logic [AW-1:0]        raddr,
    output logic signed [DW-1:0] rre,
    output logic signed [DW-1:0] rim
);
    logic [2*DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= {wre, wim};
        end
    end

    always_comb begin
        rre = mem[raddr][2*DW-1:DW];
        rim = mem[raddr][DW-1:0];
    end
endmodule

// File: rtl/tm_ctrl.sv
// Symbol fill controller: distinct-tone tracking, mode latch, ready handshake.
module tm_ctrl
    import tm_pkg::*;
#(
    parameter int N_BIG   = 512,
    parameter int N_SMALL = 64,
    parameter int TW      = $clog2(N_BIG/2),
    parameter int CW      = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_in,
    input  logic          wr_valid,
    input  logic [TW-1:0] tone,
    input  logic          rd_done,
    output logic          wr_accept,
    output logic          mode_eff,
    output logic [CW-1:0] half,
    output logic          ready
);
    localparam int HALF_B = N_BIG / 2;
    localparam logic [CW-1:0] HALF_BV = CW'(N_BIG / 2);
    localparam logic [CW-1:0] HALF_SV = CW'(N_SMALL / 2);

    tm_state_t         state_q, state_d;
    logic              mode_q;
    logic [HALF_B-1:0] mask_q;
    logic [CW-1:0]     cnt_q;
    logic              fresh, last;

    // outputs and next state
    always_comb begin
        mode_eff  = (state_q == ST_EMPTY) ? mode_in : mode_q;
        half      = mode_eff ? HALF_SV : HALF_BV;
        wr_accept = wr_valid && (state_q != ST_READY) && ({1'b0, tone} < half);
        fresh     = wr_accept && !mask_q[tone];
        last      = fresh && ((cnt_q + CW'(1)) == half);
        ready     = (state_q == ST_READY);
        state_d   = state_q;
        unique case (state_q)
            ST_EMPTY: if (last)           state_d = ST_READY;
                      else if (wr_accept) state_d = ST_FILL;
            ST_FILL:  if (last)           state_d = ST_READY;
            ST_READY: if (rd_done)        state_d = ST_EMPTY;
            default:                      state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mask_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (state_q == ST_EMPTY) mode_q <= mode_in;
            if (state_q == ST_READY && rd_done) begin
                mask_q <= '0;
                cnt_q  <= '0;
            end else if (fresh) begin
                mask_q[tone] <= 1'b1;
                cnt_q        <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/dmt_tone_mirror.sv
module dmt_tone_mirror #(
    parameter int DW      = 16,
    parameter int N_BIG   = 512,
    parameter int N_SMALL = 64,
    parameter int TW      = $clog2(N_BIG/2),
    parameter int BW      = $clog2(N_BIG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_small,
    input  logic                 wr_valid,
    input  logic [TW-1:0]        wr_tone,
    input  logic signed [DW-1:0] wr_re,
    input  logic signed [DW-1:0] wr_im,
    input  logic [BW-1:0]        rd_addr,
    input  logic                 rd_done,
    output logic signed [DW-1:0] rd_re,
    output logic signed [DW-1:0] rd_im,
    output logic                 symbol_ready
);
    localparam int HALF_B = N_BIG / 2;
    localparam int CW     = TW + 1;

    logic              wr_accept, mode_eff;
    logic [CW-1:0]     half;
    logic signed [DW-1:0] lo_re, lo_im, hi_re, hi_im;
    logic [CW-1:0]     hi_full;
    logic [TW-1:0]     hi_waddr;
    logic [TW-1:0]     lo_raddr, hi_raddr;
    logic [BW-1:0]     hi_rfull;
    logic signed [DW-1:0] lo_rre, lo_rim, hi_rre, hi_rim;

    tm_ctrl #(.N_BIG(N_BIG), .N_SMALL(N_SMALL), .TW(TW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_small), .wr_valid(wr_valid),
        .tone(wr_tone), .rd_done(rd_done), .wr_accept(wr_accept),
        .mode_eff(mode_eff), .half(half), .ready(symbol_ready)
    );

    tm_conj #(.DW(DW), .TW(TW)) u_conj (
        .tone(wr_tone), .in_re(wr_re), .in_im(wr_im),
        .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im)
    );

    always_comb begin
        hi_full  = half - {1'b0, wr_tone};
        hi_waddr = (wr_tone == '0) ? '0 : hi_full[TW-1:0];
        lo_raddr = rd_addr[TW-1:0];
        hi_rfull = rd_addr - BW'(half);
        hi_raddr = hi_rfull[TW-1:0];
    end

    // lower bank holds bins 0..N/2-1, upper bank holds bins N/2..N-1
    tm_bank #(.DW(DW), .DEPTH(HALF_B), .AW(TW)) u_lo (
        .clk(clk), .rst_n(rst_n), .we(wr_accept), .waddr(wr_tone),
        .wre(lo_re), .wim(lo_im), .raddr(lo_raddr), .rre(lo_rre), .rim(lo_rim)
    );

    tm_bank #(.DW(DW), .DEPTH(HALF_B), .AW(TW)) u_hi (
        .clk(clk), .rst_n(rst_n), .we(wr_accept), .waddr(hi_waddr),
        .wre(hi_re), .wim(hi_im), .raddr(hi_raddr), .rre(hi_rre), .rim(hi_rim)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_re <= '0;
            rd_im <= '0;
        end else if (BW'(rd_addr) < BW'(half)) begin
            rd_re <= lo_rre;
            rd_im <= lo_rim;
        end else if ({1'b0, rd_addr} < {half, 1'b0}) begin
            rd_re <= hi_rre;
            rd_im <= hi_rim;
        end else begin
            rd_re <= '0;
            rd_im <= '0;
        end
    end
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int DW = 16,
    parameter int BW = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [BW-1:0]        rd_addr,
    input logic signed [DW-1:0] rd_im,
    input logic                 rd_done,
    input logic                 symbol_ready,
    input logic                 mode_eff
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_hold_ready_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        symbol_ready && !rd_done |=> symbol_ready);

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        symbol_ready && rd_done |=> !symbol_ready);

    p_ready_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(symbol_ready) |-> $past(wr_valid));

    p_dc_real_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rd_addr) == '0) |-> (rd_im == '0));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        symbol_ready && $past(symbol_ready) |-> $stable(mode_eff));
endmodule

bind dmt_tone_mirror tm_checker #(.DW(DW), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_addr(rd_addr),
    .rd_im(rd_im), .rd_done(rd_done), .symbol_ready(symbol_ready),
    .mode_eff(mode_eff)
);

// File: tb/tb_dmt_tone_mirror.sv
module tb_dmt_tone_mirror;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_small = 1'b0;
    logic wr_valid = 1'b0;
    logic [7:0] wr_tone = '0;
    logic signed [15:0] wr_re = '0, wr_im = '0;
    logic [8:0] rd_addr = '0;
    logic rd_done = 1'b0;
    logic signed [15:0] rd_re, rd_im;
    logic symbol_ready;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmt_tone_mirror dut (
        .clk(clk), .rst_n(rst_n), .mode_small(mode_small), .wr_valid(wr_valid),
        .wr_tone(wr_tone), .wr_re(wr_re), .wr_im(wr_im), .rd_addr(rd_addr),
        .rd_done(rd_done), .rd_re(rd_re), .rd_im(rd_im), .symbol_ready(symbol_ready)
    );

    function automatic int pre(input int k); return k * 7 + 3; endfunction
    function automatic int pim(input int k); return k * 11 - 1000; endfunction

    task automatic wr(input int k, input int re, input int im);
        @(negedge clk);
        wr_valid = 1'b1; wr_tone = 8'(k); wr_re = 16'(re); wr_im = 16'(im);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk_bin(input int a, input int ere, input int eim, input string req);
        @(negedge clk); rd_addr = 9'(a);
        @(negedge clk);
        checks++;
        if (int'(rd_re) != ere || int'(rd_im) != eim) begin
            errors++;
            $display("FAIL %s bin %0d: actual (%0d,%0d) expected (%0d,%0d)",
                     req, a, rd_re, rd_im, ere, eim);
        end
    endtask

    task automatic chk_rdy(input logic exp, input string req);
        checks++;
        if (symbol_ready !== exp) begin
            errors++;
            $display("FAIL %s symbol_ready actual %0b expected %0b", req, symbol_ready, exp);
        end
    endtask

    task automatic t_reset;
        chk_rdy(1'b0, "R1");
        chk_bin(0, 0, 0, "R1");
        chk_bin(300, 0, 0, "R1");
    endtask

    task automatic t_small_fill;
        mode_small = 1'b1;
        for (int k = 0; k < 31; k++) begin
            wr(k, pre(k), pim(k));
            if (k == 0) mode_small = 1'b0;  // R11: change ignored mid-symbol
        end
        wr(7, 1234, -555);                  // R7 rewrite
        wr(40, 77, 77);                     // R8 out of range in 64-bin mode
        chk_rdy(1'b0, "R6/R7/R8 not yet ready");
        wr(31, pre(31), pim(31));
        chk_rdy(1'b1, "R6");
        chk_bin(5, pre(5), pim(5), "R2");
        chk_bin(59, pre(5), -pim(5), "R3");
        chk_bin(0, pre(0), 0, "R5");
        chk_bin(32, pim(0), 0, "R5");
        chk_bin(7, 1234, -555, "R7");
        chk_bin(57, 1234, 555, "R7");
        chk_bin(40, pre(24), -pim(24), "R8");
        chk_bin(100, 0, 0, "R11/R12");
    endtask

    task automatic t_write_locked;
        wr(5, 9, 9);
        chk_rdy(1'b1, "R9");
        chk_bin(5, pre(5), pim(5), "R9");
    endtask

    task automatic t_release;
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
        chk_rdy(1'b0, "R10");
    endtask

    task automatic t_big_fill;
        mode_small = 1'b0;
        for (int k = 0; k < 255; k++) begin
            if (k == 100) wr(k, pre(k), -32768);
            else          wr(k, pre(k), pim(k));
        end
        chk_rdy(1'b0, "R10 count restarted");
        wr(255, pre(255), pim(255));
        chk_rdy(1'b1, "R6/R11");
        chk_bin(100, pre(100), -32768, "R4");
        chk_bin(412, pre(100), 32767, "R4");
        chk_bin(256, pim(0), 0, "R5");
        chk_bin(257, pre(255), -pim(255), "R3");
        chk_bin(300, pre(212), -pim(212), "R11");
        chk_bin(212, pre(212), pim(212), "R2/R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_small_fill();
        t_write_locked();
        t_release();
        t_big_fill();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule